// File: doc/BRIEF.md
# NOR Flash Command Engine

This block models the command state machine of a parallel NOR flash on a small register array that is built into the chip. A host drives an asynchronous-style strobe bus, made of active-low chip enable, write enable and output enable, an address and write data, and reads back through a registered output. Writes are decoded against fixed unlock sequences. Accepted commands start a timed word program, a timed single-sector erase or a whole-array erase. While an operation runs, reads return progress flags in place of array data. An erase can be paused so that other sectors can be read or programmed, and then resumed.

The array is split into eleven sectors with a bottom- or top-boot layout, and a per-sector protect input blocks changes to a sector. Program and erase durations are cycle counts, so the same block serves fast simulation and slower emulation. An active-low reset aborts any running operation and returns the engine to read mode.

Top module: `nor_cmd_engine`

## Requirements
- R1: While and after `rst_n` is low, `ry_by` is 1 and `dout` is 0. Every array word reads as all ones, and any running operation is dropped.
- R2: A clock cycle is a write when `ce_n`=0, `we_n`=0 and `oe_n`=1. It is a read when `ce_n`=0, `oe_n`=0 and `we_n`=1. Any other combination is neither. `dout` changes only in the cycle after a read and holds otherwise.
- R3: Commands compare `din[7:0]`. A program is four writes: AA at UNLK_A1, 55 at UNLK_A2, A0 at UNLK_A1, then the data at the target address (defaults 'h55 and 'h2A). A write that departs from the sequence returns the decoder to idle.
- R4: A program stores the old word ANDed with the data, so bits only go from 1 to 0. `ry_by` is 0 for PROG_CYC cycles, and then the engine returns to read mode by itself.
- R5: A sector erase is six writes: AA@A1, 55@A2, 80@A1, AA@A1, 55@A2, then 30 at any address inside the sector. After ERASE_CYC busy cycles every word of that sector is all ones, and all other sectors are unchanged.
- R6: A chip erase ends the erase-setup sequence with 10 at UNLK_A1. It erases every unprotected sector and leaves protected sectors intact.
- R7: When `prot[s]` is 1, a program or erase aimed at sector s has no effect, and `ry_by` stays 1.
- R8: A read during a busy operation returns a status word in which only bits 7, 6 and 2 can be set. Bit 7 is the complement of bit 7 of the program data, and it is 0 during an erase.
- R9: Bit 6 of the status word inverts on each read while busy. Once the operation ends, reads return array data.
- R10: During an erase or a suspended erase, bit 2 inverts on each read of a sector selected for erasure. On reads of other addresses it holds its value.
- R11: B0 written to any address during an erase makes `ry_by` 1 in the next cycle and holds the erase timer. Reads of sectors that are not being erased return data. Reads of sectors being erased return a status word with bit 7 at 0, bit 6 not toggling and bit 2 toggling.
- R12: While an erase is suspended, a program to a sector that is not being erased runs normally and then returns to suspend. A program to a sector being erased is ignored.
- R13: 30 written to any address while suspended resumes the erase, which then completes as in R5.
- R14: With BOOT_TOP=0, sectors 0 to 10 span 2, 1, 1, 4, then seven times 8 units of UNIT_WORDS words, counted upward from address 0. BOOT_TOP=1 mirrors this layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| din | input | DATA_W | Write data and command byte |
| prot | input | 11 | Per-sector protect flags |
| dout | output | DATA_W | Registered read data or status |
| ry_by | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench builds the engine with UNIT_WORDS=2, PROG_CYC=6 and ERASE_CYC=40, on the bottom-boot layout. The 128-word array is small enough to sweep in full after each erase, so boundary words of neighbouring sectors are checked directly. A six-cycle program leaves room for two status reads before it completes, which exercises the bit-7 and bit-6 flags. The forty-cycle erase leaves time to read both selected and unselected sectors, to suspend, to wait longer than the whole erase time, to program another sector while suspended, and to resume before completion.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   localparam int N_SEC  = 11;
   localparam int N_UNIT = 64;

   localparam logic [7:0] K_KEY1  = 8'hAA;
   localparam logic [7:0] K_KEY2  = 8'h55;
   localparam logic [7:0] K_PROG  = 8'hA0;
   localparam logic [7:0] K_ERSET = 8'h80;
   localparam logic [7:0] K_SECT  = 8'h30;
   localparam logic [7:0] K_CHIP  = 8'h10;
   localparam logic [7:0] K_SUSP  = 8'hB0;
   localparam logic [7:0] K_RES   = 8'h30;

   typedef enum logic [2:0] {OP_READY, OP_PROG, OP_ERASE, OP_SUSP, OP_SPROG} op_state_t;
   typedef enum logic [2:0] {D_IDLE, D_U1, D_U2, D_PGM, D_E1, D_E2, D_E3} dec_state_t;

   // sector index for a unit on the low-boot layout (small sectors at address 0)
   function automatic logic [3:0] sec_low_boot(input logic [5:0] u);
      if (u < 6'd2)      return 4'd0;
      else if (u < 6'd3) return 4'd1;
      else if (u < 6'd4) return 4'd2;
      else if (u < 6'd8) return 4'd3;
      else               return {1'b0, u[5:3]} + 4'd3;
   endfunction

   function automatic logic [3:0] sec_of_unit(input logic [5:0] u, input logic top);
      return top ? (4'd10 - sec_low_boot(~u)) : sec_low_boot(u);
   endfunction
endpackage

// File: rtl/nfc_sector_map.sv
module nfc_sector_map import nfc_pkg::*; #(
   parameter int AW         = 7,
   parameter int UNIT_WORDS = 2,
   parameter int BOOT_TOP   = 0
) (
   input  logic [AW-1:0] addr,
   output logic [3:0]    sec
);
   localparam int US = $clog2(UNIT_WORDS);

   logic [5:0] unit;
   assign unit = addr[AW-1:US];

   generate
      if (BOOT_TOP != 0) begin : g_top
         assign sec = 4'd10 - sec_low_boot(~unit);
      end else begin : g_bottom
         assign sec = sec_low_boot(unit);
      end
   endgenerate
endmodule

// File: rtl/nfc_cmd_dec.sv
module nfc_cmd_dec import nfc_pkg::*; #(
   parameter int AW      = 7,
   parameter int DW      = 16,
   parameter int UNLK_A1 = 'h55,
   parameter int UNLK_A2 = 'h2A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          hold,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          go_prog,
   output logic          go_serase,
   output logic          go_chip,
   output logic          go_susp,
   output logic          go_resume
);
   localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
   localparam logic [AW-1:0] A2 = AW'(UNLK_A2);

   dec_state_t st, nxt;
   logic [7:0] cb;
   logic       at1, at2;

   assign cb  = data[7:0];
   assign at1 = (addr == A1);
   assign at2 = (addr == A2);

   always_comb begin
      nxt       = st;
      go_prog   = 1'b0;
      go_serase = 1'b0;
      go_chip   = 1'b0;
      go_susp   = 1'b0;
      go_resume = 1'b0;
      if (hold) begin
         nxt     = D_IDLE;
         go_susp = wr && (cb == K_SUSP);
      end else if (wr) begin
         nxt = D_IDLE;
         unique case (st)
            D_IDLE: begin
               if (at1 && cb == K_KEY1) nxt = D_U1;
               go_susp   = (cb == K_SUSP);
               go_resume = (cb == K_RES);
            end
            D_U1: if (at2 && cb == K_KEY2) nxt = D_U2;
            D_U2: begin
               if (at1 && cb == K_PROG)  nxt = D_PGM;
               if (at1 && cb == K_ERSET) nxt = D_E1;
            end
            D_PGM: go_prog = 1'b1;
            D_E1: if (at1 && cb == K_KEY1) nxt = D_E2;
            D_E2: if (at2 && cb == K_KEY2) nxt = D_E3;
            D_E3: begin
               go_serase = (cb == K_SECT);
               go_chip   = at1 && (cb == K_CHIP);
            end
            default: nxt = D_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= D_IDLE;
      else        st <= nxt;
   end

   // R3: the decoder is parked in idle while an operation runs
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (st == D_IDLE));
   // R2: only a qualified write moves the decoder
   a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !hold) |=> $stable(st));
endmodule

// File: rtl/nfc_op_seq.sv
module nfc_op_seq import nfc_pkg::*; #(
   parameter int AW         = 7,
   parameter int DW         = 16,
   parameter int UNIT_WORDS = 2,
   parameter int BOOT_TOP   = 0,
   parameter int PROG_CYC   = 8,
   parameter int ERASE_CYC  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_prog,
   input  logic             go_serase,
   input  logic             go_chip,
   input  logic             go_susp,
   input  logic             go_resume,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [3:0]       wr_sec,
   input  logic [N_SEC-1:0] prot,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_word,
   output logic             busy,
   output logic             prog_busy,
   output logic [N_SEC-1:0] emask,
   output logic             pbit7
);
   localparam int DEPTH = N_UNIT * UNIT_WORDS;
   localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW    = $clog2(MAXC + 1);
   localparam logic [N_SEC-1:0] ONE_SEC = {{(N_SEC-1){1'b0}}, 1'b1};

   op_state_t                 st;
   logic [CW-1:0]             pcnt, ecnt;
   logic [AW-1:0]             paddr;
   logic [DW-1:0]             pdata;
   logic [DEPTH-1:0][DW-1:0]  mem;
   logic                      tgt_prot, tgt_erasing, prog_ok;

   assign tgt_prot    = prot[wr_sec];
   assign tgt_erasing = emask[wr_sec];
   assign prog_ok     = go_prog && !tgt_prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= OP_READY;
         pcnt  <= '0;
         ecnt  <= '0;
         paddr <= '0;
         pdata <= '0;
         emask <= '0;
         mem   <= '1;
      end else begin
         unique case (st)
            OP_READY: begin
               if (prog_ok) begin
                  paddr <= wr_addr;
                  pdata <= wr_data;
                  pcnt  <= CW'(PROG_CYC - 1);
                  st    <= OP_PROG;
               end else if (go_serase && !tgt_prot) begin
                  emask <= ONE_SEC << wr_sec;
                  ecnt  <= CW'(ERASE_CYC - 1);
                  st    <= OP_ERASE;
               end else if (go_chip && |(~prot)) begin
                  emask <= ~prot;
                  ecnt  <= CW'(ERASE_CYC - 1);
                  st    <= OP_ERASE;
               end
            end
            OP_PROG, OP_SPROG: begin
               if (pcnt == '0) begin
                  mem[paddr] <= mem[paddr] & pdata;
                  st         <= (st == OP_SPROG) ? OP_SUSP : OP_READY;
               end else begin
                  pcnt <= pcnt - 1'b1;
               end
            end
            OP_ERASE: begin
               if (go_susp) begin
                  st <= OP_SUSP;
               end else if (ecnt == '0) begin
                  for (int i = 0; i < DEPTH; i++) begin
                     if (emask[sec_of_unit(6'(i / UNIT_WORDS), BOOT_TOP != 0)]) mem[i] <= '1;
                  end
                  emask <= '0;
                  st    <= OP_READY;
               end else begin
                  ecnt <= ecnt - 1'b1;
               end
            end
            OP_SUSP: begin
               if (go_resume) begin
                  st <= OP_ERASE;
               end else if (prog_ok && !tgt_erasing) begin
                  paddr <= wr_addr;
                  pdata <= wr_data;
                  pcnt  <= CW'(PROG_CYC - 1);
                  st    <= OP_SPROG;
               end
            end
            default: st <= OP_READY;
         endcase
      end
   end

   assign rd_word   = mem[rd_addr];
   assign busy      = (st == OP_PROG) || (st == OP_ERASE) || (st == OP_SPROG);
   assign prog_busy = (st == OP_PROG) || (st == OP_SPROG);
   assign pbit7     = pdata[7];

   // R7: a program aimed at a protected sector never leaves the ready state
   a_r7_prot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_READY && go_prog && prot[wr_sec]) |=> (st == OP_READY));
   // R11: suspend during erase takes effect in the next cycle
   a_r11_suspend_now: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_ERASE && go_susp) |=> (st == OP_SUSP));
   // R11: the erase timer is frozen while suspended
   a_r11_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_SUSP) |=> $stable(ecnt));
   // R5: an expiring erase returns to read mode with no sector selected
   a_r5_erase_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (st == OP_ERASE && ecnt == '0 && !go_susp) |=> (st == OP_READY && emask == '0));
endmodule

// File: rtl/nfc_readout.sv
module nfc_readout import nfc_pkg::*; #(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [3:0]       rd_sec,
   input  logic [DW-1:0]    word,
   input  logic             busy,
   input  logic             prog_busy,
   input  logic             pbit7,
   input  logic [N_SEC-1:0] emask,
   output logic [DW-1:0]    dout
);
   logic          tog6, tog2, in_er;
   logic [DW-1:0] stat;

   assign in_er = emask[rd_sec];

   always_comb begin
      stat = '0;
      if (busy) begin
         stat[7] = prog_busy ? ~pbit7 : 1'b0;
         stat[6] = ~tog6;
      end else begin
         stat[6] = tog6;
      end
      stat[2] = in_er ? ~tog2 : tog2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else if (rd) begin
         if (busy || in_er) begin
            dout <= stat;
            if (busy)  tog6 <= ~tog6;
            if (in_er) tog2 <= ~tog2;
         end else begin
            dout <= word;
         end
      end
   end

   // R2: output register moves only after a read strobe
   a_r2_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(dout));
   // R8: polling bit reports the inverse of the pending program bit
   a_r8_dq7_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && prog_busy) |=> (dout[7] == !$past(pbit7)));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine import nfc_pkg::*; #(
   parameter int  DATA_W     = 16,
   parameter int  UNIT_WORDS = 2,
   parameter int  BOOT_TOP   = 0,
   parameter int  PROG_CYC   = 8,
   parameter int  ERASE_CYC  = 64,
   parameter int  UNLK_A1    = 'h55,
   parameter int  UNLK_A2    = 'h2A,
   localparam int AW         = $clog2(N_UNIT * UNIT_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] din,
   input  logic [N_SEC-1:0]  prot,
   output logic [DATA_W-1:0] dout,
   output logic              ry_by
);
   localparam int DEPTH = N_UNIT * UNIT_WORDS;

   generate
      if (UNIT_WORDS < 1 || (UNIT_WORDS & (UNIT_WORDS - 1)) != 0) begin : g_bad_unit
         $error("UNIT_WORDS must be a power of two");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must hold a command byte");
      end
      if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
         $error("operation lengths must be at least one cycle");
      end
      if (UNLK_A1 >= DEPTH || UNLK_A2 >= DEPTH || UNLK_A1 == UNLK_A2) begin : g_bad_unlk
         $error("unlock addresses must be distinct and inside the array");
      end
   endgenerate

   logic             wr, rd, busy, prog_busy, pbit7;
   logic             go_prog, go_serase, go_chip, go_susp, go_resume;
   logic [3:0]       wr_sec, rd_sec;
   logic [N_SEC-1:0] emask;
   logic [DATA_W-1:0] rd_word;

   assign wr    = !ce_n && !we_n && oe_n;
   assign rd    = !ce_n && !oe_n && we_n;
   assign ry_by = !busy;

   nfc_sector_map #(.AW(AW), .UNIT_WORDS(UNIT_WORDS), .BOOT_TOP(BOOT_TOP)) u_map_wr (
      .addr(addr), .sec(wr_sec));

   nfc_sector_map #(.AW(AW), .UNIT_WORDS(UNIT_WORDS), .BOOT_TOP(BOOT_TOP)) u_map_rd (
      .addr(addr), .sec(rd_sec));

   nfc_cmd_dec #(.AW(AW), .DW(DATA_W), .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr(wr), .hold(busy), .addr(addr), .data(din),
      .go_prog(go_prog), .go_serase(go_serase), .go_chip(go_chip),
      .go_susp(go_susp), .go_resume(go_resume));

   nfc_op_seq #(.AW(AW), .DW(DATA_W), .UNIT_WORDS(UNIT_WORDS), .BOOT_TOP(BOOT_TOP),
                .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_serase(go_serase),
      .go_chip(go_chip), .go_susp(go_susp), .go_resume(go_resume),
      .wr_addr(addr), .wr_data(din), .wr_sec(wr_sec), .prot(prot),
      .rd_addr(addr), .rd_word(rd_word), .busy(busy), .prog_busy(prog_busy),
      .emask(emask), .pbit7(pbit7));

   nfc_readout #(.DW(DATA_W)) u_rdo (
      .clk(clk), .rst_n(rst_n), .rd(rd), .rd_sec(rd_sec), .word(rd_word),
      .busy(busy), .prog_busy(prog_busy), .pbit7(pbit7), .emask(emask), .dout(dout));

   // R4: a program start drops ready in the following cycle
   a_r4_busy_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (ry_by && go_prog && !prot[wr_sec] && emask == '0) |=> !ry_by);
endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
   localparam int UW = 2, PC = 6, EC = 40, DW = 16, AW = 7, DEPTH = 128;
   localparam logic [AW-1:0] A1 = 7'h55, A2 = 7'h2A;
   localparam logic [10:0] PROT0 = 11'b010_0000_0010;   // sectors 1 and 9

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, ce_n, we_n, oe_n, ry_by;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic [10:0]   prot;
   logic [DW-1:0] ref_mem [DEPTH];
   int n_chk = 0, n_bad = 0;

   nor_cmd_engine #(.DATA_W(DW), .UNIT_WORDS(UW), .BOOT_TOP(0), .PROG_CYC(PC),
                    .ERASE_CYC(EC), .UNLK_A1('h55), .UNLK_A2('h2A)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .prot(prot), .dout(dout), .ry_by(ry_by));

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int sec_of(input int a);
      int u;
      u = a / UW;
      if (u < 2) return 0;
      if (u < 3) return 1;
      if (u < 4) return 2;
      if (u < 8) return 3;
      return 4 + (u - 8) / 8;
   endfunction

   function automatic bit is_prot(input int a);
      return prot[sec_of(a)];
   endfunction

   // tasks are entered at a negedge and return at a negedge
   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      d = dout;
   endtask

   task automatic unlock();
      bus_wr(A1, 16'h00AA);
      bus_wr(A2, 16'h0055);
   endtask

   task automatic prog_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
      unlock();
      bus_wr(A1, 16'h00A0);
      bus_wr(a, d);
   endtask

   task automatic erase_pre();
      unlock();
      bus_wr(A1, 16'h0080);
      unlock();
   endtask

   task automatic wait_ready();
      int k = 0;
      while (!ry_by && k < 2000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic ref_erase(input int s);
      for (int i = 0; i < DEPTH; i++) if (sec_of(i) == s) ref_mem[i] = '1;
   endtask

   task automatic sweep(input string req);
      logic [DW-1:0] v;
      for (int i = 0; i < DEPTH; i++) begin
         bus_rd(AW'(i), v);
         check(v == ref_mem[i], req, v, ref_mem[i]);
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] s1, s2, v, d;
      int a;
      void'($urandom(32'd2024));
      rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = '0; din = '0; prot = PROT0;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
      repeat (3) @(negedge clk);
      check(ry_by == 1'b1 && dout == '0, "R1 reset outputs", {15'b0, ry_by}, 16'h1);
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R1 erased after reset");

      // directed program with status polling
      prog_cmd(7'd8, 16'h1234);
      check(ry_by == 1'b0, "R4 busy after program", {15'b0, ry_by}, 16'h0);
      bus_rd(7'd8, s1);
      bus_rd(7'd8, s2);
      check(s1[7] == 1'b1, "R8 dq7 inverse of data", s1, 16'h0080);
      check((s1 & 16'hFF3B) == '0, "R8 status other bits zero", s1, s1 & 16'h00C4);
      check(s1[6] != s2[6], "R9 dq6 toggles while busy", s2, s1 ^ 16'h0040);
      wait_ready();
      ref_mem[8] = 16'h1234;
      bus_rd(7'd8, v);
      check(v == 16'h1234, "R4 program result", v, 16'h1234);
      bus_rd(7'd8, s2);
      check(s2 == v, "R9 no toggle when ready", s2, v);
      prog_cmd(7'd8, 16'h0F0F);
      wait_ready();
      ref_mem[8] = 16'h1234 & 16'h0F0F;
      bus_rd(7'd8, v);
      check(v == ref_mem[8], "R4 program only clears bits", v, ref_mem[8]);

      // random programs, protected targets included
      for (int n = 0; n < 40; n++) begin
         a = $urandom % DEPTH;
         d = DW'($urandom);
         prog_cmd(AW'(a), d);
         if (is_prot(a)) begin
            check(ry_by == 1'b1, "R7 protected program stays ready", {15'b0, ry_by}, 16'h1);
         end else begin
            wait_ready();
            ref_mem[a] = ref_mem[a] & d;
         end
         bus_rd(AW'(a), v);
         check(v == ref_mem[a], "R4 random program", v, ref_mem[a]);
      end

      // broken sequences
      bus_wr(A1, 16'h00AA); bus_wr(A2, 16'h0012); bus_wr(A1, 16'h00A0); bus_wr(7'd20, 16'h0000);
      check(ry_by == 1'b1, "R3 wrong key ignored", {15'b0, ry_by}, 16'h1);
      bus_rd(7'd20, v);
      check(v == ref_mem[20], "R3 wrong key no program", v, ref_mem[20]);
      bus_wr(A1, 16'h00AA); bus_wr(A1, 16'h0055); bus_wr(A1, 16'h00A0); bus_wr(7'd21, 16'h0000);
      bus_rd(7'd21, v);
      check(v == ref_mem[21], "R3 wrong address no program", v, ref_mem[21]);

      // a cycle with oe_n low is not a write
      unlock();
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = A1; din = 16'h00A0;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      bus_wr(7'd22, 16'h0000);
      bus_rd(7'd22, v);
      check(v == ref_mem[22], "R2 oe low cycle not a write", v, ref_mem[22]);
      repeat (3) @(negedge clk);
      check(dout == v, "R2 dout holds without read", dout, v);

      // sector erase with boundary words
      prog_cmd(7'd7, 16'h0000);  wait_ready(); ref_mem[7]  = 16'h0000;
      prog_cmd(7'd9, 16'h0000);  wait_ready(); ref_mem[9]  = 16'h0000;
      prog_cmd(7'd15, 16'h0000); wait_ready(); ref_mem[15] = 16'h0000;
      prog_cmd(7'd16, 16'h0000); wait_ready(); ref_mem[16] = 16'h0000;
      erase_pre();
      bus_wr(7'd12, 16'h0030);
      check(ry_by == 1'b0, "R5 busy after erase", {15'b0, ry_by}, 16'h0);
      bus_rd(7'd9, s1);
      bus_rd(7'd9, s2);
      check(s1[2] != s2[2], "R10 dq2 toggles on erasing sector", s2, s1 ^ 16'h0004);
      check(s1[7] == 1'b0, "R8 dq7 zero during erase", s1, s1 & 16'hFF7F);
      bus_rd(7'd20, s1);
      bus_rd(7'd20, s2);
      check(s1[2] == s2[2], "R10 dq2 steady elsewhere", s2, s1);
      check(s1[6] != s2[6], "R9 dq6 toggles in erase", s2, s1 ^ 16'h0040);
      wait_ready();
      ref_erase(3);
      sweep("R14 R5 sector erase bounds");

      // protected sector erase
      prot = '0;
      prog_cmd(7'd100, 16'h0000); wait_ready(); ref_mem[100] = 16'h0000;
      prot = PROT0;
      erase_pre();
      bus_wr(7'd100, 16'h0030);
      check(ry_by == 1'b1, "R7 protected erase stays ready", {15'b0, ry_by}, 16'h1);
      bus_rd(7'd100, v);
      check(v == 16'h0000, "R7 protected erase no effect", v, 16'h0000);

      // suspend / program / resume
      prog_cmd(7'd40, 16'h0000); wait_ready(); ref_mem[40] = 16'h0000;
      prog_cmd(7'd50, 16'h5555); wait_ready(); ref_mem[50] = ref_mem[50] & 16'h5555;
      erase_pre();
      bus_wr(7'd33, 16'h0030);
      repeat (5) @(negedge clk);
      bus_wr(7'd7, 16'h00B0);
      check(ry_by == 1'b1, "R11 ready after suspend", {15'b0, ry_by}, 16'h1);
      repeat (EC + 10) @(negedge clk);
      check(ry_by == 1'b1, "R11 erase held", {15'b0, ry_by}, 16'h1);
      bus_rd(7'd50, v);
      check(v == ref_mem[50], "R11 read other sector", v, ref_mem[50]);
      bus_rd(7'd40, s1);
      bus_rd(7'd40, s2);
      check(s1[2] != s2[2] && s1[6] == s2[6] && s1[7] == 1'b0, "R11 suspended status", s2, s1 ^ 16'h0004);
      prog_cmd(7'd51, 16'h00FF);
      check(ry_by == 1'b0, "R12 program in suspend busy", {15'b0, ry_by}, 16'h0);
      wait_ready();
      ref_mem[51] = ref_mem[51] & 16'h00FF;
      bus_rd(7'd51, v);
      check(v == ref_mem[51], "R12 program in suspend", v, ref_mem[51]);
      bus_rd(7'd41, v);
      check((v & 16'hFFBB) == '0, "R12 back in suspend", v, v & 16'h0044);
      prog_cmd(7'd42, 16'h0000);
      check(ry_by == 1'b1, "R12 erasing target ignored", {15'b0, ry_by}, 16'h1);
      bus_wr(7'd0, 16'h0030);
      check(ry_by == 1'b0, "R13 resume busy", {15'b0, ry_by}, 16'h0);
      wait_ready();
      ref_erase(5);
      sweep("R13 resumed erase result");

      // chip erase honours protection
      prog_cmd(7'd0, 16'h0000);  wait_ready(); ref_mem[0]  = 16'h0000;
      prog_cmd(7'd70, 16'h0000); wait_ready(); ref_mem[70] = 16'h0000;
      erase_pre();
      bus_wr(A1, 16'h0010);
      check(ry_by == 1'b0, "R6 chip erase busy", {15'b0, ry_by}, 16'h0);
      wait_ready();
      for (int s = 0; s < 11; s++) if (!prot[s]) ref_erase(s);
      sweep("R6 chip erase result");

      // hardware reset aborts a program
      prog_cmd(7'd60, 16'h0000);
      check(ry_by == 1'b0, "R1 busy before abort", {15'b0, ry_by}, 16'h0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ry_by == 1'b1, "R1 ready after abort", {15'b0, ry_by}, 16'h1);
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
      sweep("R1 array after abort");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule